// File: doc/BRIEF.md
# Speculative Load Disambiguation Unit

This block keeps a small program-ordered queue of in-flight memory operations. Stores and loads take a slot in that order. A store's address arrives later, once address generation has finished. A load asks for permission to issue. If every older store in the queue already has a known address, the load is granted. If some older store is still unresolved, the load may still go ahead, but only when an alias predictor entry selected by the load's instruction identifier currently allows it. A denied load keeps asking until the older stores resolve.

When a store's address arrives, the queue is scanned for loads that are younger than the store, have already executed, and used the same full word address. Such a load read stale data. The oldest one is reported for re-execution, and every matching load loses its executed state. The predictor entry of the reported load is forced to the deny value. A fixed penalty window then blocks all load grants. Loads that retire after executing move their predictor entry back toward allow, one step at a time.

Allocation is a valid/ready stream: an operation is taken on a cycle where `alloc_valid` and `alloc_ready` are both high, and `alloc_ready` drops only while every slot is occupied. The load request works the same way: `ld_grant` acts as ready for the request on the same cycle, and a requester that is not granted keeps its request up and retries. Store resolution and retirement are plain event pulses.

Top module: `spec_ld_disambig`

## Requirements
- R1: The queue holds DEPTH (default 8) operations, and each one receives a slot tag `alloc_tag` equal to the current tail slot. The tag advances by one per accepted allocation and wraps from DEPTH-1 to 0. `alloc_ready` is low exactly when all DEPTH slots are occupied, and an allocation offered while it is low changes nothing.
- R2: A load request is granted on the same cycle when the tag names an occupied, not yet executed load, no penalty window is active, and no older store in the queue has an unresolved address.
- R3: After reset every predictor entry is in the allow state. A load whose older stores are still unresolved is therefore granted unless its entry has been trained to deny.
- R4: A load whose predictor entry denies bypass is not granted while any older store is unresolved. It is granted on the first request after the last of those stores resolves.
- R5: A store resolving to address A causes `replay_valid` on the next cycle exactly when some load younger than the store has executed with word address A. Loads older than the store, and loads with other addresses, never cause a replay.
- R6: When several younger loads match, `replay_tag` names the one closest in age to the store. All matching loads return to the not-executed state and must be granted again.
- R7: A replay opens a penalty window: `penalty_busy` is high for exactly PENALTY (default 20) cycles, starting on the cycle `replay_valid` is high. No load is granted while `penalty_busy` is high.
- R8: Each predictor entry is a CTR_W-bit (default 2) saturating counter, indexed by the low IDX_W bits of the load's identifier. A load allows bypass when its counter is at least 2^(CTR_W-1). A replay sets the reported load's counter to 0. Each retirement of an executed load adds one, saturating at the maximum, and a clear wins over an add to the same entry on the same cycle.
- R9: A load granted on the same cycle that an older store resolves to the same address counts as executed for that scan, and it is reported for replay on the next cycle.
- R10: `retire_valid` frees the oldest occupied slot, in program order. A retirement offered while the queue is empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation offer |
| alloc_ready | output | 1 | A free slot exists |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_pc | input | PC_W | Instruction identifier of the load (ignored for stores) |
| alloc_tag | output | PTR_W | Slot that the offered operation will occupy |
| st_res_valid | input | 1 | Store address resolved this cycle |
| st_res_tag | input | PTR_W | Slot of the resolving store |
| st_res_addr | input | ADDR_W | Word address of the store |
| ld_req_valid | input | 1 | Load asks to issue |
| ld_req_tag | input | PTR_W | Slot of the requesting load |
| ld_req_addr | input | ADDR_W | Word address of the load |
| ld_grant | output | 1 | Load may issue this cycle |
| retire_valid | input | 1 | Retire the oldest slot |
| replay_valid | output | 1 | A load must be re-executed |
| replay_tag | output | PTR_W | Slot of the load to re-execute |
| penalty_busy | output | 1 | Penalty window active; loads blocked |

## Verification
The case that needs the most care is a load being granted on the same cycle that an older store resolves to the load's address. The scan then has to use the load's new address, which is not yet stored in the queue. The bench provokes this by raising a load request and a store resolution together, with matching addresses, while the predictor is still in its reset allow state. It expects a grant on that cycle, a replay naming that load on the next cycle, and a full penalty window that starts at the replay. A behavioural model of queue occupancy, ages, predictor counters and the penalty window predicts every output on every cycle.

// File: rtl/sld_pkg.sv
package sld_pkg;
  typedef enum logic [1:0] {
    PR_HOLD  = 2'd0,
    PR_STEP  = 2'd1,
    PR_CLEAR = 2'd2
  } pred_op_e;
endpackage

// File: rtl/sld_alias_pred.sv
module sld_alias_pred
  import sld_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_allow,
  input  logic             clr_valid,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             inc_valid,
  input  logic [IDX_W-1:0] inc_idx
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] THRESH = CTR_W'(1) << (CTR_W - 1);

  logic [CTR_W-1:0] ctr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    pred_op_e op;
    always_comb begin
      if (clr_valid && clr_idx == IDX_W'(g))      op = PR_CLEAR;
      else if (inc_valid && inc_idx == IDX_W'(g)) op = PR_STEP;
      else                                         op = PR_HOLD;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) ctr[g] <= CTR_MAX;
      else begin
        case (op)
          PR_CLEAR: ctr[g] <= '0;
          PR_STEP:  if (ctr[g] != CTR_MAX) ctr[g] <= ctr[g] + 1'b1;
          default:  ctr[g] <= ctr[g];
        endcase
      end
    end
  end

  assign rd_allow = (ctr[rd_idx] >= THRESH);
endmodule

// File: rtl/sld_conflict_scan.sv
module sld_conflict_scan #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [PTR_W-1:0]  head,
  input  logic              st_valid,
  input  logic [PTR_W-1:0]  st_tag,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DEPTH-1:0]  ld_exec,
  input  logic [DEPTH-1:0]  ld_live,
  input  logic [ADDR_W-1:0] e_addr [DEPTH],
  input  logic              fl_valid,
  input  logic [PTR_W-1:0]  fl_tag,
  input  logic [ADDR_W-1:0] fl_addr,
  output logic              hit,
  output logic [PTR_W-1:0]  hit_tag,
  output logic [DEPTH-1:0]  hit_mask
);
  logic [PTR_W-1:0] st_age;
  assign st_age = st_tag - head;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cand
    logic [PTR_W-1:0] age;
    logic             old_hit, new_hit;
    assign age     = PTR_W'(i) - head;
    assign old_hit = ld_exec[i] && (e_addr[i] == st_addr);
    assign new_hit = ld_live[i] && fl_valid && (fl_tag == PTR_W'(i)) && (fl_addr == st_addr);
    assign hit_mask[i] = st_valid && (age > st_age) && (old_hit || new_hit);
  end

  // Walk from youngest to oldest so the last match kept is the oldest.
  always_comb begin
    hit     = 1'b0;
    hit_tag = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (hit_mask[head + PTR_W'(k)]) begin
        hit     = 1'b1;
        hit_tag = head + PTR_W'(k);
      end
    end
  end
endmodule

// File: rtl/sld_penalty_timer.sv
module sld_penalty_timer #(
  parameter int PENALTY = 20,
  localparam int CNT_W = $clog2(PENALTY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CNT_W'(PENALTY);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/spec_ld_disambig.sv
module spec_ld_disambig #(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 16,
  parameter int PC_W    = 8,
  parameter int IDX_W   = 4,
  parameter int CTR_W   = 2,
  parameter int PENALTY = 20,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic              alloc_is_store,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic [PTR_W-1:0]  alloc_tag,
  input  logic              st_res_valid,
  input  logic [PTR_W-1:0]  st_res_tag,
  input  logic [ADDR_W-1:0] st_res_addr,
  input  logic              ld_req_valid,
  input  logic [PTR_W-1:0]  ld_req_tag,
  input  logic [ADDR_W-1:0] ld_req_addr,
  output logic              ld_grant,
  input  logic              retire_valid,
  output logic              replay_valid,
  output logic [PTR_W-1:0]  replay_tag,
  output logic              penalty_busy
);
  logic [DEPTH-1:0]  e_v, e_st, e_ak, e_ex;
  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [PC_W-1:0]   e_pc   [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;

  logic alloc_fire, retire_fire, st_ok, pred_allow, any_older_unres;
  logic hit;
  logic [PTR_W-1:0] hit_tag;
  logic [DEPTH-1:0] hit_mask, older_unres, ld_live;

  assign alloc_ready = (count != CNT_W'(DEPTH));
  assign alloc_tag   = tail;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign retire_fire = retire_valid && (count != '0);
  assign st_ok       = st_res_valid && e_v[st_res_tag] && e_st[st_res_tag] && !e_ak[st_res_tag];
  assign ld_live     = e_v & ~e_st;

  // Older stores whose address is still unknown, relative to the requester.
  for (genvar i = 0; i < DEPTH; i++) begin : g_older
    logic [PTR_W-1:0] age_i, age_req;
    assign age_i   = PTR_W'(i) - head;
    assign age_req = ld_req_tag - head;
    assign older_unres[i] = e_v[i] && e_st[i] && !e_ak[i] && (age_i < age_req);
  end
  assign any_older_unres = |older_unres;

  sld_alias_pred #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_pred (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (e_pc[ld_req_tag][IDX_W-1:0]),
    .rd_allow  (pred_allow),
    .clr_valid (hit),
    .clr_idx   (e_pc[hit_tag][IDX_W-1:0]),
    .inc_valid (retire_fire && !e_st[head] && e_ex[head]),
    .inc_idx   (e_pc[head][IDX_W-1:0])
  );

  assign ld_grant = ld_req_valid && !penalty_busy && ld_live[ld_req_tag] && !e_ex[ld_req_tag]
                    && (!any_older_unres || pred_allow);

  sld_conflict_scan #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_scan (
    .head     (head),
    .st_valid (st_ok),
    .st_tag   (st_res_tag),
    .st_addr  (st_res_addr),
    .ld_exec  (ld_live & e_ex),
    .ld_live  (ld_live),
    .e_addr   (e_addr),
    .fl_valid (ld_grant),
    .fl_tag   (ld_req_tag),
    .fl_addr  (ld_req_addr),
    .hit      (hit),
    .hit_tag  (hit_tag),
    .hit_mask (hit_mask)
  );

  sld_penalty_timer #(.PENALTY(PENALTY)) u_pen (
    .clk   (clk),
    .rst_n (rst_n),
    .start (hit),
    .busy  (penalty_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0; tail <= '0; count <= '0;
      replay_valid <= 1'b0; replay_tag <= '0;
    end else begin
      if (retire_fire) head <= head + 1'b1;
      if (alloc_fire)  tail <= tail + 1'b1;
      case ({alloc_fire, retire_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      replay_valid <= hit;
      replay_tag   <= hit_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_v <= '0; e_st <= '0; e_ak <= '0; e_ex <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_addr[i] <= '0;
        e_pc[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (retire_fire && head == PTR_W'(i)) e_v[i] <= 1'b0;
        if (alloc_fire && tail == PTR_W'(i)) begin
          e_v[i]  <= 1'b1;
          e_st[i] <= alloc_is_store;
          e_ak[i] <= 1'b0;
          e_ex[i] <= 1'b0;
          e_pc[i] <= alloc_pc;
        end
        if (st_ok && st_res_tag == PTR_W'(i)) begin
          e_ak[i]   <= 1'b1;
          e_addr[i] <= st_res_addr;
        end
        if (ld_grant && ld_req_tag == PTR_W'(i)) begin
          e_ex[i]   <= 1'b1;
          e_addr[i] <= ld_req_addr;
        end
        if (hit_mask[i]) e_ex[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sld_disambig_chk.sv
module sld_disambig_chk #(
  parameter int DEPTH   = 8,
  parameter int PENALTY = 20
) (
  input logic clk,
  input logic rst_n,
  input logic alloc_valid,
  input logic alloc_ready,
  input logic retire_valid,
  input logic st_res_valid,
  input logic ld_req_valid,
  input logic ld_grant,
  input logic replay_valid,
  input logic penalty_busy
);
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int RUN_W = $clog2(PENALTY + 2);

  logic [OCC_W-1:0] occ;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + OCC_W'(alloc_valid && alloc_ready) - OCC_W'(retire_valid && occ != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            run_q <= '0;
    else if (replay_valid) run_q <= RUN_W'(1);
    else if (penalty_busy) run_q <= run_q + 1'b1;
    else                   run_q <= '0;
  end

  p_full_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCC_W'(DEPTH)) |-> !alloc_ready);
  p_room_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ < OCC_W'(DEPTH)) |-> alloc_ready);
  p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_grant |-> ld_req_valid);
  p_replay_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> $past(st_res_valid));
  p_no_grant_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    penalty_busy |-> !ld_grant);
  p_replay_opens_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> penalty_busy);
  p_window_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!penalty_busy && run_q != '0) |-> (run_q == RUN_W'(PENALTY)));
endmodule

bind spec_ld_disambig sld_disambig_chk #(.DEPTH(DEPTH), .PENALTY(PENALTY)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_valid  (alloc_valid),
  .alloc_ready  (alloc_ready),
  .retire_valid (retire_valid),
  .st_res_valid (st_res_valid),
  .ld_req_valid (ld_req_valid),
  .ld_grant     (ld_grant),
  .replay_valid (replay_valid),
  .penalty_busy (penalty_busy)
);

// File: tb/spec_ld_disambig_tb.sv
`timescale 1ns/1ps
module spec_ld_disambig_tb;
  localparam int DEPTH = 8, ADDR_W = 16, PC_W = 8, IDX_W = 4, CTR_W = 2, PENALTY = 20;
  localparam int PTR_W = 3;
  localparam int CMAX = (1 << CTR_W) - 1, THR = 1 << (CTR_W - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_is_store = 0, st_res_valid = 0, ld_req_valid = 0, retire_valid = 0;
  logic [PC_W-1:0] alloc_pc = '0;
  logic [PTR_W-1:0] st_res_tag = '0, ld_req_tag = '0;
  logic [ADDR_W-1:0] st_res_addr = '0, ld_req_addr = '0;
  logic alloc_ready, ld_grant, replay_valid, penalty_busy;
  logic [PTR_W-1:0] alloc_tag, replay_tag;

  always #4 clk = ~clk;

  spec_ld_disambig #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PC_W(PC_W), .IDX_W(IDX_W),
                     .CTR_W(CTR_W), .PENALTY(PENALTY)) u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_is_store(alloc_is_store), .alloc_pc(alloc_pc), .alloc_tag(alloc_tag),
    .st_res_valid(st_res_valid), .st_res_tag(st_res_tag), .st_res_addr(st_res_addr),
    .ld_req_valid(ld_req_valid), .ld_req_tag(ld_req_tag), .ld_req_addr(ld_req_addr),
    .ld_grant(ld_grant), .retire_valid(retire_valid), .replay_valid(replay_valid),
    .replay_tag(replay_tag), .penalty_busy(penalty_busy));

  int checks = 0, fails = 0;
  bit done = 0;

  // Behavioural reference state
  int m_v[DEPTH], m_st[DEPTH], m_ak[DEPTH], m_ex[DEPTH], m_addr[DEPTH], m_pc[DEPTH];
  int m_ctr[1 << IDX_W];
  int m_head = 0, m_tail = 0, m_count = 0, m_pen = 0, m_rv = 0, m_rtag = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int age(input int idx);
    return (idx - m_head + DEPTH) % DEPTH;
  endfunction

  task automatic step(input string req, input bit av, input bit ais, input int apc,
                      input bit sv, input int stag, input int saddr,
                      input bit lv, input int ltag, input int laddr, input bit rv);
    int exp_grant, unres, st_ok, hit, htag, best, hd, pre_ex_head;
    int clr[DEPTH];
    alloc_valid = av; alloc_is_store = ais; alloc_pc = PC_W'(apc);
    st_res_valid = sv; st_res_tag = PTR_W'(stag); st_res_addr = ADDR_W'(saddr);
    ld_req_valid = lv; ld_req_tag = PTR_W'(ltag); ld_req_addr = ADDR_W'(laddr);
    retire_valid = rv;
    #1;
    unres = 0;
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && m_st[i] && !m_ak[i] && age(i) < age(ltag)) unres = 1;
    exp_grant = (lv && m_pen == 0 && m_v[ltag] && !m_st[ltag] && !m_ex[ltag] &&
                 (!unres || m_ctr[m_pc[ltag] % (1 << IDX_W)] >= THR)) ? 1 : 0;
    check("R1", "alloc_ready", int'(alloc_ready), (m_count < DEPTH) ? 1 : 0);
    check("R1", "alloc_tag", int'(alloc_tag), m_tail);
    check(req, "ld_grant", int'(ld_grant), exp_grant);
    check(req, "replay_valid", int'(replay_valid), m_rv);
    if (m_rv) check("R6", "replay_tag", int'(replay_tag), m_rtag);
    check("R7", "penalty_busy", int'(penalty_busy), (m_pen != 0) ? 1 : 0);
    @(posedge clk);
    // model update
    st_ok = (sv && m_v[stag] && m_st[stag] && !m_ak[stag]) ? 1 : 0;
    hit = 0; htag = 0; best = DEPTH;
    for (int i = 0; i < DEPTH; i++) begin
      clr[i] = 0;
      if (st_ok && m_v[i] && !m_st[i] && age(i) > age(stag)) begin
        if ((m_ex[i] && m_addr[i] == saddr) || (exp_grant && ltag == i && laddr == saddr)) begin
          clr[i] = 1; hit = 1;
          if (age(i) < best) begin best = age(i); htag = i; end
        end
      end
    end
    hd = m_head;
    pre_ex_head = m_ex[hd];
    if (hit) m_pen = PENALTY; else if (m_pen > 0) m_pen--;
    if (st_ok) begin m_ak[stag] = 1; m_addr[stag] = saddr; end
    if (exp_grant) begin m_ex[ltag] = 1; m_addr[ltag] = laddr; end
    for (int i = 0; i < DEPTH; i++) if (clr[i]) m_ex[i] = 0;
    if (rv && m_count > 0) begin
      if (!m_st[hd] && pre_ex_head && m_ctr[m_pc[hd] % (1 << IDX_W)] < CMAX)
        m_ctr[m_pc[hd] % (1 << IDX_W)]++;
      m_v[hd] = 0; m_head = (m_head + 1) % DEPTH; m_count--;
      if (av && m_count + 1 < DEPTH) ;
    end
    if (hit) m_ctr[m_pc[htag] % (1 << IDX_W)] = 0;
    if (av && (m_count + ((rv && m_count >= 0 && hd != m_head) ? 1 : 0)) < DEPTH) begin
      m_v[m_tail] = 1; m_st[m_tail] = ais; m_ak[m_tail] = 0; m_ex[m_tail] = 0;
      m_pc[m_tail] = apc % (1 << PC_W);
      m_tail = (m_tail + 1) % DEPTH; m_count++;
    end
    m_rv = hit; m_rtag = htag;
    @(negedge clk);
  endtask

  task automatic idle(input string req, input int n);
    for (int k = 0; k < n; k++) step(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic alloc(input string req, input bit is_st, input int pc, output int tag);
    tag = m_tail;
    step(req, 1, is_st, pc, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic retry(input string req, input int tag, input int addr, input int n);
    for (int k = 0; k < n; k++) step(req, 0, 0, 0, 0, 0, 0, 1, tag, addr, 0);
  endtask

  task automatic drain(input string req, input int n);
    for (int k = 0; k < n; k++) step(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    int s, l, l2;
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 0; m_st[i] = 0; m_ak[i] = 0; m_ex[i] = 0; m_addr[i] = 0; m_pc[i] = 0;
    end
    for (int i = 0; i < (1 << IDX_W); i++) m_ctr[i] = CMAX;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    idle("R1", 1);
    // R3 bypass in reset allow state, R5 conflict, R7 penalty window
    alloc("R1", 1, 0, s);
    alloc("R1", 0, 5, l);
    step("R3", 0, 0, 0, 0, 0, 0, 1, l, 'h40, 0);
    step("R5", 0, 0, 0, 1, s, 'h40, 0, 0, 0, 0);
    retry("R7", l, 'h40, PENALTY + 1);
    drain("R10", 2);
    // R4 trained deny waits for older stores
    alloc("R4", 1, 0, s);
    alloc("R4", 0, 5, l);
    retry("R4", l, 'h80, 2);
    step("R4", 0, 0, 0, 1, s, 'h90, 0, 0, 0, 0);
    retry("R4", l, 'h80, 1);
    drain("R8", 2);
    // R8 counter stepped back to allow; R5 different address is no conflict
    alloc("R8", 1, 0, s);
    alloc("R8", 0, 5, l);
    retry("R8", l, 'h50, 1);
    step("R5", 0, 0, 0, 1, s, 'h99, 0, 0, 0, 0);
    idle("R5", 1);
    drain("R10", 2);
    // R5 older load is not a candidate; queue wraps
    alloc("R2", 0, 9, l2);
    alloc("R5", 1, 0, s);
    alloc("R5", 0, 10, l);
    retry("R2", l2, 'h10, 1);
    retry("R3", l, 'h10, 1);
    step("R5", 0, 0, 0, 1, s, 'h10, 0, 0, 0, 0);
    retry("R7", l, 'h10, PENALTY + 1);
    drain("R10", 3);
    // R6 oldest of several matches
    alloc("R6", 1, 0, s);
    alloc("R6", 0, 1, l);
    alloc("R6", 0, 2, l2);
    retry("R6", l, 'h20, 1);
    retry("R6", l2, 'h20, 1);
    step("R6", 0, 0, 0, 1, s, 'h20, 0, 0, 0, 0);
    retry("R7", l, 'h20, PENALTY + 1);
    retry("R6", l2, 'h20, 1);
    drain("R10", 3);
    // R9 grant and resolve on the same cycle
    alloc("R9", 1, 0, s);
    alloc("R9", 0, 3, l);
    step("R9", 0, 0, 0, 1, s, 'h30, 1, l, 'h30, 0);
    retry("R9", l, 'h30, PENALTY + 1);
    drain("R10", 2);
    // R1 full queue stalls allocation
    for (int k = 0; k < DEPTH + 1; k++) step("R1", 1, k % 2, 7, 0, 0, 0, 0, 0, 0, 0);
    // R10 retirement in order, ignored when empty
    drain("R10", DEPTH + 2);
    idle("R10", 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
      $finish;
    end
  end
endmodule